// File: doc/BRIEF.md
# Eight-Channel Countdown Timer Bank with Shared Prescaler

This block holds eight 16-bit down-counters behind a byte-wide register port. Each counter has an interval value that software writes as two bytes. Three control bytes hold one bit per counter: a reload request, a run enable and an auto-reload mode. The four upper counters (bits 4 to 7) step on every symbol strobe. The four lower counters (bits 0 to 3) step once per 1,024 strobes. The slow step comes from one 10-bit prescaler that all four lower counters share.

A counter acts only on a step of its own time base. A pending reload request loads the interval on that step and then clears itself. If software withdraws the request before the step arrives, nothing happens. An enabled counter decrements on each step. A one-shot counter stops at zero. An auto-reload counter loads its interval again in place of reaching zero. Each expiry produces a one-cycle pulse on a dedicated output and sets a sticky status bit, which software clears by writing 1.

Top module: `tmr_bank`

## Requirements
- R1: After synchronous reset, every register reads 0, every count reads 0, expire_o is 0 and the prescaler count is 0.
- R2: Register map on the 6-bit address:
  - 0x00 reload request, 0x01 enable, 0x02 auto-reload, 0x03 status (write 1 to clear). Bit i of each belongs to counter i.
  - Interval of counter i: low byte at 0x10+2i, high byte at 0x11+2i.
  - Current count of counter i (read-only): low byte at 0x20+2i, high byte at 0x21+2i.
  - Unmapped addresses read 0.
- R3: A set reload-request bit loads the interval into the counter on the next step of that counter's time base, with no decrement on that step. Without a step, the count does not change.
- R4: The reload-request bit clears itself on the step that performs the load. A software write in that same cycle wins. A bit that is cleared by software before a step causes no load.
- R5: An enabled counter with no pending reload decrements by one per step. A counter that is disabled, or that sees no step, holds its value. An enable bit that is set and then cleared before a step causes no decrement.
- R6: In one-shot mode (auto-reload bit 0), an enabled step at count 1 goes to 0 and expires. At 0 the counter stays at 0 and does not expire again.
- R7: In auto-reload mode, an enabled step at count 1 or 0 loads the interval and expires. With an interval of 0, the counter therefore expires on every step.
- R8: expire_o[i] is high for exactly the one cycle after the clock edge of the expiring step. The matching status bit is set at that same edge and stays set until software writes 1 to it. A new expiry wins over a clear in the same cycle.
- R9: Counters 4 to 7 step on every cycle with sym_tick high. Counters 0 to 3 step only on every 1,024th sym_tick after reset (the 1024th, 2048th, and so on).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sym_tick | input | 1 | Symbol-rate strobe, one cycle per symbol |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 6 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 6 | Read address |
| rd_data | output | 8 | Read data (combinational from rd_addr) |
| expire_o | output | 8 | One-cycle expiry pulse per counter |

## Verification
The fast counters are driven with an irregular strobe pattern that skips one strobe in three. This pattern separates "decrement per step" from "decrement per clock" and shows that hold works between steps. Reload requests and enables are set and withdrawn between steps, which shows whether a control bit is sampled on the step or at the write. The bench mixes one-shot and auto-reload counters, an interval of zero, and an interval change during a run, so the reload value and the expiry timing are checked in every mode. A run of more than four thousand strobes crosses several prescaler wraps and confirms that the lower counters step only on every 1,024th strobe.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 16;

  // register map
  localparam int A_RESTART = 'h00;
  localparam int A_ENABLE  = 'h01;
  localparam int A_CONT    = 'h02;
  localparam int A_STATUS  = 'h03;
  localparam int A_IVAL    = 'h10;
  localparam int A_COUNT   = 'h20;

  typedef logic [CNT_W-1:0] cnt_t;

  typedef struct packed {
    cnt_t value;
    logic expired;
    logic loaded;
  } step_t;

  // one counter step: reload request first, then countdown / auto-reload
  function automatic step_t next_count(cnt_t cur, cnt_t ival, logic tick,
                                       logic rs, logic en, logic cont);
    step_t r;
    r.value   = cur;
    r.expired = 1'b0;
    r.loaded  = 1'b0;
    if (tick) begin
      if (rs) begin
        r.value  = ival;
        r.loaded = 1'b1;
      end else if (en) begin
        if (cur > cnt_t'(1)) begin
          r.value = cur - cnt_t'(1);
        end else if (cont) begin
          r.value   = ival;
          r.expired = 1'b1;
        end else if (cur == cnt_t'(1)) begin
          r.value   = '0;
          r.expired = 1'b1;
        end
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int PRE_W = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic sym_tick,
  output logic slow_tick
);
  logic [PRE_W-1:0] pre;

  assign slow_tick = sym_tick & (&pre);

  always_ff @(posedge clk) begin
    if (rst)           pre <= '0;
    else if (sym_tick) pre <= pre + 1'b1;
  end

  // R9
  pre_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    slow_tick |=> (pre == '0));
endmodule

// File: rtl/tmr_unit.sv
module tmr_unit
  import tmr_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic restart,
  input  logic enable,
  input  logic cont,
  input  cnt_t interval,
  output cnt_t count,
  output logic expire_o,
  output logic taken,
  output logic exp_evt
);
  step_t nx;

  always_comb nx = next_count(count, interval, tick, restart, enable, cont);

  assign taken   = nx.loaded;
  assign exp_evt = nx.expired;

  always_ff @(posedge clk) begin
    if (rst) begin
      count    <= '0;
      expire_o <= 1'b0;
    end else begin
      count    <= nx.value;
      expire_o <= nx.expired;
    end
  end

  // R5
  hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !tick |=> ($stable(count) && !expire_o));
  // R3
  restart_load_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && restart) |=> (count == $past(interval)) && !expire_o);
  // R6
  oneshot_rest_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && enable && !restart && !cont && count == '0) |=> (count == '0) && !expire_o);
  // R8
  pulse_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
    expire_o |-> $past(tick));
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int N_TIMERS = 8,
  parameter int ADDR_W   = 6
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           wr_en,
  input  logic [ADDR_W-1:0]              wr_addr,
  input  logic [BYTE_W-1:0]              wr_data,
  input  logic [N_TIMERS-1:0]            taken,
  input  logic [N_TIMERS-1:0]            exp_evt,
  output logic [N_TIMERS-1:0]            restart,
  output logic [N_TIMERS-1:0]            enable,
  output logic [N_TIMERS-1:0]            cont,
  output logic [N_TIMERS-1:0]            status,
  output logic [N_TIMERS-1:0][CNT_W-1:0] interval
);
  logic wr_rs, wr_en_reg, wr_ct, wr_st;
  logic [N_TIMERS-1:0] clr;

  assign wr_rs     = wr_en && (wr_addr == ADDR_W'(A_RESTART));
  assign wr_en_reg = wr_en && (wr_addr == ADDR_W'(A_ENABLE));
  assign wr_ct     = wr_en && (wr_addr == ADDR_W'(A_CONT));
  assign wr_st     = wr_en && (wr_addr == ADDR_W'(A_STATUS));
  assign clr       = wr_st ? wr_data[N_TIMERS-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      restart <= '0;
      enable  <= '0;
      cont    <= '0;
      status  <= '0;
    end else begin
      restart <= wr_rs ? wr_data[N_TIMERS-1:0] : (restart & ~taken);
      if (wr_en_reg) enable <= wr_data[N_TIMERS-1:0];
      if (wr_ct)     cont   <= wr_data[N_TIMERS-1:0];
      status <= (status & ~clr) | exp_evt;
    end
  end

  for (genvar i = 0; i < N_TIMERS; i++) begin : g_ival
    always_ff @(posedge clk) begin
      if (rst) begin
        interval[i] <= '0;
      end else if (wr_en) begin
        if (wr_addr == ADDR_W'(A_IVAL + 2*i))     interval[i][7:0]  <= wr_data;
        if (wr_addr == ADDR_W'(A_IVAL + 2*i + 1)) interval[i][15:8] <= wr_data;
      end
    end
  end

  // R4
  restart_clear_chk: assert property (@(posedge clk) disable iff (rst)
    ((|taken) && !wr_rs) |=> ((restart & $past(taken)) == '0));
  // R8
  status_set_chk: assert property (@(posedge clk) disable iff (rst)
    (|exp_evt) |=> ((status & $past(exp_evt)) == $past(exp_evt)));
endmodule

// File: rtl/tmr_bank.sv
module tmr_bank
  import tmr_pkg::*;
#(
  parameter int N_TIMERS = 8,
  parameter int N_SLOW   = 4,
  parameter int PRE_W    = 10,
  parameter int ADDR_W   = 6
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                sym_tick,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [BYTE_W-1:0]   wr_data,
  input  logic [ADDR_W-1:0]   rd_addr,
  output logic [BYTE_W-1:0]   rd_data,
  output logic [N_TIMERS-1:0] expire_o
);
  logic                           slow_tick;
  logic [N_TIMERS-1:0]            restart, enable, cont, status, taken, exp_evt;
  logic [N_TIMERS-1:0][CNT_W-1:0] interval, counts;

  tmr_prescale #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst(rst), .sym_tick(sym_tick), .slow_tick(slow_tick)
  );

  tmr_regs #(.N_TIMERS(N_TIMERS), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .taken(taken), .exp_evt(exp_evt), .restart(restart), .enable(enable),
    .cont(cont), .status(status), .interval(interval)
  );

  for (genvar i = 0; i < N_TIMERS; i++) begin : g_unit
    logic tick_i;
    if (i < N_SLOW) begin : g_slow
      assign tick_i = slow_tick;
    end else begin : g_fast
      assign tick_i = sym_tick;
    end
    tmr_unit u_t (
      .clk(clk), .rst(rst), .tick(tick_i), .restart(restart[i]),
      .enable(enable[i]), .cont(cont[i]), .interval(interval[i]),
      .count(counts[i]), .expire_o(expire_o[i]), .taken(taken[i]),
      .exp_evt(exp_evt[i])
    );
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr == ADDR_W'(A_RESTART)) rd_data[N_TIMERS-1:0] = restart;
    if (rd_addr == ADDR_W'(A_ENABLE))  rd_data[N_TIMERS-1:0] = enable;
    if (rd_addr == ADDR_W'(A_CONT))    rd_data[N_TIMERS-1:0] = cont;
    if (rd_addr == ADDR_W'(A_STATUS))  rd_data[N_TIMERS-1:0] = status;
    for (int i = 0; i < N_TIMERS; i++) begin
      if (rd_addr == ADDR_W'(A_IVAL + 2*i))      rd_data = interval[i][7:0];
      if (rd_addr == ADDR_W'(A_IVAL + 2*i + 1))  rd_data = interval[i][15:8];
      if (rd_addr == ADDR_W'(A_COUNT + 2*i))     rd_data = counts[i][7:0];
      if (rd_addr == ADDR_W'(A_COUNT + 2*i + 1)) rd_data = counts[i][15:8];
    end
  end
endmodule

// File: tb/sim_tmr_bank.sv
`timescale 1ns/1ps
module sim_tmr_bank;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic st = 1'b0, we = 1'b0;
  logic [5:0] wa = '0, ra = '0;
  logic [7:0] wd = '0;
  logic [7:0] rd_data, expire_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // reference state
  int m_cnt[8], m_ival[8];
  int m_rs, m_en, m_ct, m_st, m_exp, m_pre;

  always #2 clk = ~clk;

  tmr_bank u0 (
    .clk(clk), .rst(rst), .sym_tick(st), .wr_en(we), .wr_addr(wa),
    .wr_data(wd), .rd_addr(ra), .rd_data(rd_data), .expire_o(expire_o)
  );

  task automatic chk(input int act, input int exp, input string tag);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 8; i++) begin m_cnt[i] = 0; m_ival[i] = 0; end
    m_rs = 0; m_en = 0; m_ct = 0; m_st = 0; m_exp = 0; m_pre = 0;
  endtask

  task automatic model_step();
    bit slow;
    int took, ex;
    int nc[8];
    slow = st && (m_pre == 1023);
    took = 0; ex = 0;
    for (int i = 0; i < 8; i++) begin
      bit tk;
      tk = (i < 4) ? slow : st;
      nc[i] = m_cnt[i];
      if (tk && m_rs[i]) begin
        nc[i] = m_ival[i];
        took |= (1 << i);
      end else if (tk && m_en[i]) begin
        if (m_cnt[i] == 0) begin
          if (m_ct[i]) begin nc[i] = m_ival[i]; ex |= (1 << i); end
        end else if (m_cnt[i] == 1) begin
          ex |= (1 << i);
          nc[i] = m_ct[i] ? m_ival[i] : 0;
        end else begin
          nc[i] = m_cnt[i] - 1;
        end
      end
    end
    for (int i = 0; i < 8; i++) m_cnt[i] = nc[i];
    m_exp = ex;
    if (we && wa == 6'h03) m_st = m_st & ~int'(wd);
    m_st = m_st | ex;
    if (we && wa == 6'h00) m_rs = wd; else m_rs = m_rs & ~took;
    if (we && wa == 6'h01) m_en = wd;
    if (we && wa == 6'h02) m_ct = wd;
    for (int i = 0; i < 8; i++) begin
      if (we && wa == 6'(16 + 2*i)) m_ival[i] = (m_ival[i] & 'hFF00) | wd;
      if (we && wa == 6'(17 + 2*i)) m_ival[i] = (m_ival[i] & 'h00FF) | (int'(wd) << 8);
    end
    if (st) m_pre = (m_pre + 1) % 1024;
  endtask

  function automatic int m_read(input int a);
    if (a == 0) return m_rs;
    if (a == 1) return m_en;
    if (a == 2) return m_ct;
    if (a == 3) return m_st;
    if (a >= 16 && a < 32) return (m_ival[(a-16)/2] >> (8*(a%2))) & 'hFF;
    if (a >= 32 && a < 48) return (m_cnt[(a-32)/2] >> (8*(a%2))) & 'hFF;
    return 0;
  endfunction

  // one clock: drive at falling edge, step model at rising edge, compare pulses after
  task automatic cyc(input logic s, input logic w, input int a, input int d);
    @(negedge clk);
    st = s; we = w; wa = 6'(a); wd = 8'(d);
    @(posedge clk);
    model_step();
    #1;
    chk(int'(expire_o), m_exp, "R8 expire pulse");
    st = 1'b0; we = 1'b0;
  endtask

  task automatic rd_chk(input int a, input string tag);
    ra = 6'(a);
    #0.1;
    chk(int'(rd_data), m_read(a), tag);
  endtask

  task automatic dump(input string tag);
    for (int a = 0; a < 4; a++) rd_chk(a, tag);
    for (int a = 16; a < 48; a++) rd_chk(a, tag);
    rd_chk(6'h3F, "R2 unmapped");
  endtask

  task automatic wr(input int a, input int d);
    cyc(1'b0, 1'b1, a, d);
  endtask

  task automatic set_ival(input int i, input int v);
    wr(16 + 2*i, v & 'hFF);
    wr(17 + 2*i, (v >> 8) & 'hFF);
  endtask

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #0.5;
    chk(int'(expire_o), 0, "R1 reset pulse");
    dump("R1 reset state");

    set_ival(0, 2); set_ival(1, 'h0102); set_ival(2, 1); set_ival(3, 0);
    set_ival(4, 3); set_ival(5, 0); set_ival(6, 5); set_ival(7, 'h1234);
    dump("R2 interval bytes");

    // R3: pending reload without a step leaves counts alone
    wr(0, 'hFF);
    repeat (3) cyc(1'b0, 1'b0, 0, 0);
    dump("R3 no step no load");
    // R4: withdraw bit 7 before the step
    wr(0, 'h7F);
    cyc(1'b1, 1'b0, 0, 0);
    dump("R4 withdrawn reload and self clear");

    // R5: enable set then cleared before any step
    wr(1, 'hF0);
    wr(1, 'h70);
    wr(2, 'h60);
    dump("R5 enable withdrawn");
    wr(0, 'h8F);
    cyc(1'b1, 1'b0, 0, 0);
    dump("R3 reload counter 7");
    wr(1, 'h70);

    // R5 R6 R7: irregular strobe pattern
    for (int k = 0; k < 40; k++) begin
      cyc((k % 3) != 0, 1'b0, 0, 0);
      if (k % 8 == 7) dump("R7 irregular steps");
    end

    // R8: status write-1-to-clear
    wr(3, 'h30);
    dump("R8 status clear");
    // new interval picked up on next auto reload; R7
    set_ival(6, 2);
    wr(2, 'h70);
    for (int k = 0; k < 20; k++) cyc(1'b1, (k == 5), 3, 'hFF);
    dump("R7 new interval and R8 status");

    // R9: slow counters through several prescaler wraps
    wr(1, 'h77);
    wr(2, 'h61);
    for (int k = 0; k < 4700; k++) begin
      cyc(1'b1, 1'b0, 0, 0);
      if (k % 1000 == 999) dump("R9 slow steps");
    end
    wr(3, 'hFF);
    for (int k = 0; k < 600; k++) cyc((k % 2) == 0, 1'b0, 0, 0);
    dump("R9 final state");

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got hung expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule